// File: doc/BRIEF.md
# Word-Addressed 16-bit Multicycle Processor Core

This block is a compact processor core that repeatedly fetches a 16-bit instruction word, decodes it and executes it, one instruction every three clock cycles. It holds eight 16-bit general-purpose registers, a 16-bit program counter and a 16-bit status word. It talks to one synchronous, word-addressed memory port. Every address names one 16-bit word, and read data arrives one cycle after the address is presented.

The instruction set has three register-to-register operations: a modulo-2^16 sum, a bitwise inverse and a bitwise conjunction. Every other opcode acts as a no-operation and only advances the program counter. A combinational debug port returns any general-purpose register, so an external model can compare register contents after every instruction. The memory write path is present on the port list, but no instruction drives it.

Top module: `wordcore16`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `mem_addr` equals the RESET_PC parameter (default 0xB000), every register reads 0 through the debug port and `status` reads 0.
- R2: `mem_addr` always carries the program counter. It is constant through the fetch and decode cycles and increases by exactly 1 when an instruction completes.
- R3: The program counter wraps from 0xFFFF to 0x0000.
- R4: An instruction word carries the opcode in bits [15:12], the destination register in [11:9], source A in [8:6] and source B in [5:3]. Bits [2:0] have no effect.
- R5: Opcode 0x0 writes the low 16 bits of A + B to the destination.
- R6: Opcode 0x1 writes the bitwise inverse of A to the destination. The source B field has no effect.
- R7: Opcode 0x2 writes A & B to the destination.
- R8: After opcodes 0x0 to 0x2, status bit 1 is set when the result is zero, bit 2 copies result bit 15, and bit 3 holds the carry out of opcode 0x0. Bit 3 is cleared by opcodes 0x1 and 0x2.
- R9: Opcodes 0x3 to 0xF change no register and no status bit, and only advance the program counter.
- R10: Each instruction takes exactly three cycles: fetch (address out), decode (instruction word captured) and execute. The destination register and the program counter change only at the end of the execute cycle.
- R11: Status bit 0 (ring), bit 4 (interrupt raised) and bits [15:5] stay 0. `mem_we` and `mem_wdata` stay 0.
- R12: `dbg_data` shows, in the same cycle, the register selected by `dbg_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Word address, equal to the program counter |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| mem_wdata | output | 16 | Write data, held at 0 |
| mem_we | output | 1 | Write enable, held at 0 |
| dbg_sel | input | 3 | Register index for the debug read |
| dbg_data | output | 16 | Contents of the selected register |
| status | output | 16 | Status word: ring, zero, negative, carry, interrupt |

## Verification
The bench builds the core with RESET_PC set to 0xFFF0 and keeps the default widths of 16 bits and eight registers. With that reset vector, the program counter crosses from 0xFFFF to 0x0000 after sixteen instructions, which puts the wrap within reach of a short run. The bench keeps its own model of the registers, the counter and the flags, and compares the full state after every instruction. It also checks at the execute cycle that no result has appeared early. Directed words cover carry out, a zero result, a set negative bit, a non-zero unused field, a varied B field under the inverse, and unknown opcodes that follow set flags.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;

  localparam int unsigned INSTR_W = 16;

  localparam logic [3:0] OPC_ADD = 4'h0;
  localparam logic [3:0] OPC_NOT = 4'h1;
  localparam logic [3:0] OPC_AND = 4'h2;

  typedef enum logic [1:0] {
    PH_FETCH  = 2'd0,
    PH_DECODE = 2'd1,
    PH_EXEC   = 2'd2
  } phase_t;

  typedef enum logic [1:0] {
    ALU_ADD  = 2'd0,
    ALU_NOT  = 2'd1,
    ALU_AND  = 2'd2,
    ALU_NONE = 2'd3
  } alu_op_t;

  // instruction word, most significant field first
  typedef struct packed {
    logic [3:0] opc;
    logic [2:0] rd;
    logic [2:0] ra;
    logic [2:0] rb;
    logic [2:0] spare;
  } instr_t;

  // status word, bit 0 is ring
  typedef struct packed {
    logic [10:0] rsvd;
    logic        irq;
    logic        cf;
    logic        nf;
    logic        zf;
    logic        ring;
  } stat_t;

endpackage

// File: rtl/cpu16_regfile.sv
module cpu16_regfile #(
  parameter int W = 16,
  parameter int N = 8,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b,
  input  logic [AW-1:0] dbg_addr,
  output logic [W-1:0]  dbg_data
);

  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata_a  = regs[raddr_a];
  assign rdata_b  = regs[raddr_b];
  assign dbg_data = regs[dbg_addr];

  // a write lands in the addressed register one edge later
  assert_rf_write_R10: assert property (@(posedge clk) disable iff (rst)
    we |=> regs[$past(waddr)] == $past(wdata));

  // nothing moves without a write strobe
  assert_rf_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !we |=> regs[$past(dbg_addr)] == $past(dbg_data));

endmodule

// File: rtl/cpu16_alu.sv
module cpu16_alu
  import cpu16_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_t       op,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  output logic [W-1:0]  y,
  output logic          zf,
  output logic          nf,
  output logic          cf,
  output logic          valid
);

  logic [W:0] sum;

  always_comb begin
    sum   = {1'b0, a} + {1'b0, b};
    y     = '0;
    cf    = 1'b0;
    valid = 1'b1;
    case (op)
      ALU_ADD: begin
        y  = sum[W-1:0];
        cf = sum[W];
      end
      ALU_NOT: y = ~a;
      ALU_AND: y = a & b;
      default: valid = 1'b0;
    endcase
    zf = (y == '0);
    nf = y[W-1];
  end

  // carry can only come from the adder
  always_comb begin
    if (op != ALU_ADD) assert_carry_add_only_R8: assert (!cf);
  end

endmodule

// File: rtl/cpu16_seq.sv
module cpu16_seq
  import cpu16_pkg::*;
#(
  parameter int          W        = 16,
  parameter logic [W-1:0] RESET_PC = 16'hB000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [INSTR_W-1:0] mem_rdata,
  input  logic         ex_valid,
  input  logic         ex_zf,
  input  logic         ex_nf,
  input  logic         ex_cf,
  output instr_t       ir,
  output alu_op_t      alu_op,
  output logic         rf_we,
  output logic [W-1:0] pc,
  output stat_t        stat
);

  phase_t phase;
  logic   unused_spare;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_FETCH;
      pc    <= RESET_PC;
      ir    <= '0;
      stat  <= '0;
    end else begin
      case (phase)
        PH_FETCH:  phase <= PH_DECODE;
        PH_DECODE: begin
          ir    <= instr_t'(mem_rdata);
          phase <= PH_EXEC;
        end
        PH_EXEC: begin
          pc    <= pc + 1'b1;
          phase <= PH_FETCH;
          if (ex_valid) begin
            stat.zf <= ex_zf;
            stat.nf <= ex_nf;
            stat.cf <= ex_cf;
          end
        end
        default: phase <= PH_FETCH;
      endcase
    end
  end

  always_comb begin
    case (ir.opc)
      OPC_ADD: alu_op = ALU_ADD;
      OPC_NOT: alu_op = ALU_NOT;
      OPC_AND: alu_op = ALU_AND;
      default: alu_op = ALU_NONE;
    endcase
  end

  assign rf_we        = (phase == PH_EXEC) && ex_valid;
  assign unused_spare = ^ir.spare;

  assert_fetch_next_R10: assert property (@(posedge clk) disable iff (rst)
    phase == PH_FETCH |=> phase == PH_DECODE);
  assert_decode_next_R10: assert property (@(posedge clk) disable iff (rst)
    phase == PH_DECODE |=> phase == PH_EXEC);
  assert_exec_next_R10: assert property (@(posedge clk) disable iff (rst)
    phase == PH_EXEC |=> phase == PH_FETCH);
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    phase == PH_EXEC |=> pc == W'($past(pc) + 1));
  assert_pc_hold_R2: assert property (@(posedge clk) disable iff (rst)
    phase != PH_EXEC |=> $stable(pc));
  assert_pc_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_EXEC && pc == '1) |=> pc == '0);
  assert_nop_flags_R9: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_EXEC && !ex_valid) |=> $stable(stat));
  assert_logic_carry_R8: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_EXEC && (alu_op == ALU_NOT || alu_op == ALU_AND)) |=> !stat.cf);
  assert_fixed_bits_R11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (!stat.ring && !stat.irq && stat.rsvd == '0));

endmodule

// File: rtl/wordcore16.sv
module wordcore16
  import cpu16_pkg::*;
#(
  parameter int          W        = 16,
  parameter int          NREGS    = 8,
  parameter logic [15:0] RESET_PC = 16'hB000
) (
  input  logic        clk,
  input  logic        rst,
  output logic [15:0] mem_addr,
  input  logic [15:0] mem_rdata,
  output logic [15:0] mem_wdata,
  output logic        mem_we,
  input  logic [2:0]  dbg_sel,
  output logic [15:0] dbg_data,
  output logic [15:0] status
);

  localparam int AW = $clog2(NREGS);

  instr_t        ir;
  alu_op_t       alu_op;
  logic          rf_we;
  logic [W-1:0]  pc;
  stat_t         stat;
  logic [W-1:0]  opa, opb, res;
  logic          ex_zf, ex_nf, ex_cf, ex_valid;

  cpu16_seq #(.W(W), .RESET_PC(RESET_PC)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .mem_rdata(mem_rdata),
    .ex_valid (ex_valid),
    .ex_zf    (ex_zf),
    .ex_nf    (ex_nf),
    .ex_cf    (ex_cf),
    .ir       (ir),
    .alu_op   (alu_op),
    .rf_we    (rf_we),
    .pc       (pc),
    .stat     (stat)
  );

  cpu16_regfile #(.W(W), .N(NREGS)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (rf_we),
    .waddr   (AW'(ir.rd)),
    .wdata   (res),
    .raddr_a (AW'(ir.ra)),
    .raddr_b (AW'(ir.rb)),
    .rdata_a (opa),
    .rdata_b (opb),
    .dbg_addr(AW'(dbg_sel)),
    .dbg_data(dbg_data)
  );

  cpu16_alu #(.W(W)) u_alu (
    .op   (alu_op),
    .a    (opa),
    .b    (opb),
    .y    (res),
    .zf   (ex_zf),
    .nf   (ex_nf),
    .cf   (ex_cf),
    .valid(ex_valid)
  );

  assign mem_addr  = pc;
  assign mem_wdata = '0;
  assign mem_we    = 1'b0;
  assign status    = stat;

endmodule

// File: tb/sim_wordcore16.sv
`timescale 1ns/1ps
module sim_wordcore16;

  localparam logic [15:0] RV = 16'hFFF0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr, mem_rdata, mem_wdata, dbg_data, status;
  logic        mem_we;
  logic [2:0]  dbg_sel = '0;
  logic [15:0] instr_q = 16'hF000;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  logic [15:0] m_regs [8];
  logic [15:0] m_pc;
  logic        m_z, m_n, m_c;

  always #2 clk = ~clk;
  always @(posedge clk) mem_rdata <= instr_q;

  wordcore16 #(.RESET_PC(RV)) u0 (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .dbg_sel(dbg_sel),
    .dbg_data(dbg_data), .status(status)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input int i, output logic [15:0] v);
    dbg_sel = 3'(i);
    #0.1;
    v = dbg_data;
  endtask

  function automatic logic [16:0] alu_ref(input logic [3:0] opc, input logic [15:0] a,
                                          input logic [15:0] b);
    case (opc)
      4'h0: alu_ref = {1'b0, a} + {1'b0, b};
      4'h1: alu_ref = {1'b0, ~a};
      4'h2: alu_ref = {1'b0, a & b};
      default: alu_ref = '0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] opc);
    case (opc)
      4'h0: tag_of = "R5 sum";
      4'h1: tag_of = "R6 inverse";
      4'h2: tag_of = "R7 conjunction";
      default: tag_of = "R9 no-op";
    endcase
  endfunction

  task automatic compare_all(input string tag);
    logic [15:0] v;
    for (int i = 0; i < 8; i++) begin
      rd(i, v);
      chk({tag, " reg"}, v, m_regs[i]);
    end
    chk({tag, " R2 pc"}, mem_addr, m_pc);
    chk({tag, " R8 flags"}, status, {12'h000, m_c, m_n, m_z, 1'b0});
    chk("R11 write port", {mem_we, mem_wdata[14:0]} | {15'h0, mem_wdata[15]}, 16'h0);
  endtask

  task automatic run_instr(input logic [15:0] ins);
    logic [15:0] v;
    logic [16:0] r;
    logic [3:0]  opc;
    opc = ins[15:12];
    chk("R2 fetch address", mem_addr, m_pc);
    instr_q = ins;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rd(ins[11:9], v);
    chk("R10 no early writeback", v, m_regs[ins[11:9]]);
    chk("R10 pc held until execute ends", mem_addr, m_pc);
    @(posedge clk);
    @(negedge clk);
    if (opc <= 4'h2) begin
      r = alu_ref(opc, m_regs[ins[8:6]], m_regs[ins[5:3]]);
      m_regs[ins[11:9]] = r[15:0];
      m_z = (r[15:0] == 16'h0);
      m_n = r[15];
      m_c = r[16];
    end
    m_pc = m_pc + 16'h1;
    compare_all(tag_of(opc));
  endtask

  function automatic logic [15:0] enc(input logic [3:0] o, input int d, input int a,
                                      input int b, input logic [2:0] sp);
    enc = {o, 3'(d), 3'(a), 3'(b), sp};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) m_regs[i] = 16'h0;
    m_pc = RV; m_z = 0; m_n = 0; m_c = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 reset pc during reset", mem_addr, RV);
    rst = 1'b0;
    // R1: state right after reset release
    compare_all("R1 reset");

    // directed corner cases
    run_instr(enc(4'h1, 1, 0, 5, 3'b000));  // R6 ~0 -> FFFF, N set
    run_instr(enc(4'h0, 2, 1, 1, 3'b000));  // R5 FFFF+FFFF carry
    run_instr(enc(4'h0, 3, 0, 0, 3'b111));  // R4 spare bits set, zero result
    run_instr(enc(4'h1, 4, 2, 7, 3'b101));  // R6 B field varied
    run_instr(enc(4'h2, 5, 2, 4, 3'b000));  // R7 FFFE & 0001 -> zero
    run_instr(enc(4'h0, 6, 2, 2, 3'b000));  // set carry again
    run_instr(enc(4'h7, 6, 1, 1, 3'b000));  // R9 unknown op keeps flags
    run_instr(enc(4'hF, 1, 2, 3, 3'b111));  // R9
    run_instr(enc(4'h3, 0, 1, 2, 3'b010));  // R9
    run_instr(enc(4'h2, 7, 1, 6, 3'b000));  // R7
    // R12: debug read returns register in same cycle
    rd(7, v);
    chk("R12 debug read", v, m_regs[7]);

    // constrained random, crosses the 0xFFFF -> 0x0000 wrap (R3)
    for (int k = 0; k < 400; k++) begin
      int r;
      logic [3:0] o;
      r = int'($urandom_range(9, 0));
      o = (r < 3) ? 4'h0 : (r < 6) ? 4'h2 : (r < 8) ? 4'h1 : 4'($urandom_range(15, 3));
      run_instr(enc(o, int'($urandom_range(7, 0)), int'($urandom_range(7, 0)),
                    int'($urandom_range(7, 0)), 3'($urandom_range(7, 0))));
      if (m_pc == 16'h0001) chk("R3 pc wrapped", mem_addr, 16'h0001);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule